// File: doc/BRIEF.md
# USB Device Interrupt Flag Register

This block holds the interrupt flags of a USB device controller and presents them to a CPU through a small register port. The protocol engine sends one-cycle event pulses: per-endpoint transfer request (an IN token found no valid transmit data, so the endpoint answers NACK until data is loaded and enabled), per-endpoint transmit complete (the host acknowledged a packet with ACK), suspend detected and awake detected (resume or bus reset). A bus-power detect input is asynchronous and is synchronised inside the block. Any change of its synchronised level, whether a connect or a disconnect, raises a connection flag.

Software clears a flag by writing 0 to its bit position. Writing 1 to a bit leaves it unchanged, so a single write can clear one flag and leave the others alone. Two enable registers mask the flags. The OR of all enabled flags drives one level interrupt request line. The bus register also shows a configuration-valid status level that no write can change. The bus port is a plain register interface. Reads are combinational and writes take effect at the clock edge, so there is no back-pressure to handle.

Top module: `usbirq_top`

## Requirements
- R1: Writing to a flag register clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1, from the next clock edge on.
- R2: When an event pulse and a software clear hit the same flag in the same cycle, the flag ends up set.
- R3: The bus register (address 1) reads 0x20 after reset with cfg_valid_i low. Bits 7:4 always read 0010, bit 3 always reads 0, and writes never change these bits.
- R4: Bit 2 of the bus register equals cfg_valid_i in the same cycle, and writing to the register has no effect on it.
- R5: Bit 0 of the bus register (suspend flag) sets on a susp_det_i pulse only while susp_mode_i is 1.
- R6: Bit 1 of the bus register (awake flag) sets on a wake_det_i pulse only while susp_mode_i is 1.
- R7: The endpoint register (address 0) holds the transfer-request flag of endpoint i at bit i and the transmit-complete flag of endpoint i at bit NUM_EP+i. Each flag sets at the clock edge that samples its pulse.
- R8: Bit 2*NUM_EP of the endpoint register (connection flag) sets on every change of vbus_i, whether rising or falling. It is set after the third clock edge that follows the change (two synchroniser stages, then edge detect).
- R9: The endpoint enable register (address 2) reads back all 8 written bits, and only its low 2*NUM_EP+1 bits act as masks. The bus enable register (address 3) keeps bits 1:0 and reads 0 above them. irq_o is high exactly when some flag is 1 and its enable bit is 1.
- R10: After reset all flags and enable bits are 0, irq_o is 0, and the endpoint register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| bus_cs_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 2 | 0 endpoint flags, 1 bus flags, 2 endpoint enables, 3 bus enables |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| ep_treq_i | input | NUM_EP | Transfer-request event pulses, one per endpoint |
| ep_tdone_i | input | NUM_EP | Transmit-complete event pulses, one per endpoint |
| vbus_i | input | 1 | Asynchronous bus-power detect level |
| susp_mode_i | input | 1 | Suspend-mode control level that gates the suspend and awake flags |
| susp_det_i | input | 1 | Suspend condition detected pulse |
| wake_det_i | input | 1 | Resume or bus reset detected pulse |
| cfg_valid_i | input | 1 | Configuration-valid status level |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with NUM_EP=3, which gives a 7-bit endpoint flag field. The endpoint register then has only its top bit left as a non-flag bit, so R9 is checked with a single spare enable bit. All three endpoints' request and complete pulses are driven at random, mixed with clears and enable writes. The default SYNC_STAGES=2 sets the three-edge latency checked for R8.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    REG_FLAG_EP  = 2'd0,
    REG_FLAG_BUS = 2'd1,
    REG_EN_EP    = 2'd2,
    REG_EN_BUS   = 2'd3
  } reg_sel_e;

  // Constant pattern of the top nibble of the bus flag register
  localparam logic [3:0] BUS_RSVD_HI = 4'b0010;
  localparam int BUS_FLAGS = 2;
endpackage

// File: rtl/usbirq_sync.sv
module usbirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/usbirq_flags.sv
module usbirq_flags #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] flag_q;

  // A hardware set outranks a software clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign q_o = flag_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_chk
      a_r2_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> q_o[i]);
      a_r1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !set_i[i]) |=> !q_o[i]);
      a_r1_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
    end
  endgenerate
endmodule

// File: rtl/usbirq_top.sv
module usbirq_top
  import usbirq_pkg::*;
#(
  parameter int NUM_EP      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_cs_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NUM_EP-1:0] ep_treq_i,
  input  logic [NUM_EP-1:0] ep_tdone_i,
  input  logic              vbus_i,
  input  logic              susp_mode_i,
  input  logic              susp_det_i,
  input  logic              wake_det_i,
  input  logic              cfg_valid_i,
  output logic              irq_o
);
  localparam int EPW      = 2 * NUM_EP + 1;
  localparam int CONN_BIT = 2 * NUM_EP;
  localparam int EP_PAD   = DATA_W - EPW;

  // Register write decode
  logic wr_en, wr_ep, wr_bus, wr_en_ep, wr_en_bus;
  assign wr_en     = bus_cs_i & bus_we_i;
  assign wr_ep     = wr_en && (bus_addr_i == REG_FLAG_EP);
  assign wr_bus    = wr_en && (bus_addr_i == REG_FLAG_BUS);
  assign wr_en_ep  = wr_en && (bus_addr_i == REG_EN_EP);
  assign wr_en_bus = wr_en && (bus_addr_i == REG_EN_BUS);

  // Bus-power detect: synchronise, then flag any level change
  logic vbus_s, vbus_q, conn_pulse;

  usbirq_sync #(.STAGES(SYNC_STAGES)) u_vbus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (vbus_i),
    .q_o   (vbus_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vbus_q <= 1'b0;
    else         vbus_q <= vbus_s;
  end

  assign conn_pulse = vbus_s ^ vbus_q;

  // Endpoint flag bank
  logic [EPW-1:0] set_ep, clr_ep, flag_ep;
  assign set_ep = {conn_pulse, ep_tdone_i, ep_treq_i};
  assign clr_ep = wr_ep ? ~bus_wdata_i[EPW-1:0] : '0;

  usbirq_flags #(.W(EPW)) u_ep_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_ep),
    .clr_i (clr_ep),
    .q_o   (flag_ep)
  );

  // Bus event flag bank: bit 0 suspend, bit 1 awake, both gated by suspend mode
  logic [BUS_FLAGS-1:0] set_bus, clr_bus, flag_bus;
  assign set_bus = {wake_det_i & susp_mode_i, susp_det_i & susp_mode_i};
  assign clr_bus = wr_bus ? ~bus_wdata_i[BUS_FLAGS-1:0] : '0;

  usbirq_flags #(.W(BUS_FLAGS)) u_bus_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_bus),
    .clr_i (clr_bus),
    .q_o   (flag_bus)
  );

  // Enable registers
  logic [DATA_W-1:0]    en_ep_q;
  logic [BUS_FLAGS-1:0] en_bus_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_ep_q  <= '0;
      en_bus_q <= '0;
    end else begin
      if (wr_en_ep)  en_ep_q  <= bus_wdata_i;
      if (wr_en_bus) en_bus_q <= bus_wdata_i[BUS_FLAGS-1:0];
    end
  end

  // Interrupt request
  logic irq_ep, irq_bus;
  assign irq_ep  = |(flag_ep & en_ep_q[EPW-1:0]);
  assign irq_bus = |(flag_bus & en_bus_q);
  assign irq_o   = irq_ep | irq_bus;

  // Read multiplexer
  logic [DATA_W-1:0] rd_ep, rd_bus;

  generate
    if (EP_PAD > 0) begin : g_pad
      assign rd_ep = {{EP_PAD{1'b0}}, flag_ep};
    end else begin : g_full
      assign rd_ep = flag_ep;
    end
  endgenerate

  assign rd_bus = {BUS_RSVD_HI, 1'b0, cfg_valid_i, flag_bus};

  always_comb begin
    case (bus_addr_i)
      REG_FLAG_EP:  bus_rdata_o = rd_ep;
      REG_FLAG_BUS: bus_rdata_o = rd_bus;
      REG_EN_EP:    bus_rdata_o = en_ep_q;
      default:      bus_rdata_o = {{(DATA_W-BUS_FLAGS){1'b0}}, en_bus_q};
    endcase
  end

  // Checks across the decode, gating and synchroniser paths
  a_r5_susp_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_bus[0]) |-> $past(susp_mode_i && susp_det_i));
  a_r6_wake_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_bus[1]) |-> $past(susp_mode_i && wake_det_i));
  a_r8_conn_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_ep[CONN_BIT]) |-> $past(vbus_s != vbus_q));
  a_r4_cfg_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == REG_FLAG_BUS) |-> (bus_rdata_o[2] == cfg_valid_i));
endmodule

// File: tb/usbirq_top_bench.sv
module usbirq_top_bench;
  localparam int NEP  = 3;
  localparam int EPW  = 2 * NEP + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wd = 0;
  logic [7:0] rdata;
  logic [NEP-1:0] treq = 0, tdone = 0;
  logic vbus = 0, smode = 0, sdet = 0, wdet = 0, cfg = 0;
  logic irq;

  int checks = 0;
  int fails  = 0;
  bit done = 0;

  // Bench model state
  logic [EPW-1:0] m_fep = 0;
  logic [1:0]     m_fbus = 0;
  logic [7:0]     m_enep = 0;
  logic [1:0]     m_enbus = 0;
  logic m_s1 = 0, m_s2 = 0, m_prev = 0;

  always #5 clk = ~clk;

  usbirq_top #(.NUM_EP(NEP), .SYNC_STAGES(2)) u_usbirq_top (
    .clk_i(clk), .rst_ni(rst_n), .bus_cs_i(cs), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wd), .bus_rdata_o(rdata),
    .ep_treq_i(treq), .ep_tdone_i(tdone), .vbus_i(vbus),
    .susp_mode_i(smode), .susp_det_i(sdet), .wake_det_i(wdet),
    .cfg_valid_i(cfg), .irq_o(irq)
  );

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {{(8-EPW){1'b0}}, m_fep};
      2'd1: return {4'b0010, 1'b0, cfg, m_fbus};
      2'd2: return m_enep;
      default: return {6'b0, m_enbus};
    endcase
  endfunction

  function automatic logic exp_irq();
    return (|(m_fep & m_enep[EPW-1:0])) | (|(m_fbus & m_enbus));
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // One bus cycle: check combinational outputs, then advance the model at the edge
  task automatic run(input string rtag);
    logic pulse;
    logic [EPW-1:0] clr_ep;
    logic [1:0] clr_bus;
    #1;
    if (cs && !we) check8(rtag, rdata, exp_read(addr));
    check8("R9 irq", {7'b0, irq}, {7'b0, exp_irq()});
    @(posedge clk);
    pulse   = m_s2 ^ m_prev;
    m_prev  = m_s2;
    m_s2    = m_s1;
    m_s1    = vbus;
    clr_ep  = (cs && we && addr == 2'd0) ? ~wd[EPW-1:0] : '0;
    clr_bus = (cs && we && addr == 2'd1) ? ~wd[1:0] : '0;
    m_fep   = {pulse, tdone, treq} | (m_fep & ~clr_ep);
    m_fbus  = {wdet & smode, sdet & smode} | (m_fbus & ~clr_bus);
    if (cs && we && addr == 2'd2) m_enep  = wd;
    if (cs && we && addr == 2'd3) m_enbus = wd[1:0];
    #1;
    cs = 0; we = 0; treq = 0; tdone = 0; sdet = 0; wdet = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string rtag);
    cs = 1; we = 0; addr = a; run(rtag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cs = 1; we = 1; addr = a; wd = d; run("R1 write");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #1;

    // R10 reset state, R3 reset value of the bus register
    rd(2'd0, "R10 ep flags");
    rd(2'd1, "R3 reset 0x20");
    rd(2'd2, "R10 ep enables");
    rd(2'd3, "R10 bus enables");

    // R7 endpoint event flags
    treq = 3'b010; rd(2'd0, "R7");
    tdone = 3'b101; rd(2'd0, "R7 after request");
    rd(2'd0, "R7 both kinds");

    // R1 write one keeps, write zero clears a single flag
    wr(2'd0, 8'hFF); rd(2'd0, "R1 keep");
    wr(2'd0, 8'hFD); rd(2'd0, "R1 clear one");
    wr(2'd0, 8'h00); rd(2'd0, "R1 clear all");

    // R2 set and clear in the same cycle
    cs = 1; we = 1; addr = 2'd0; wd = 8'h00; treq = 3'b001; run("R2");
    rd(2'd0, "R2 set wins");

    // R3 reserved bits unaffected by writes, R4 status level
    wr(2'd1, 8'hFF); rd(2'd1, "R3 write ones");
    wr(2'd1, 8'h00); rd(2'd1, "R3 write zeros");
    cfg = 1; rd(2'd1, "R4 cfg high");
    wr(2'd1, 8'h00); rd(2'd1, "R4 after write");
    cfg = 0; rd(2'd1, "R4 cfg low");

    // R5 suspend gating, R6 awake gating
    smode = 0; sdet = 1; rd(2'd1, "R5 pre");
    rd(2'd1, "R5 gated off");
    smode = 1; sdet = 1; rd(2'd1, "R5 pre");
    rd(2'd1, "R5 set");
    smode = 0; wdet = 1; rd(2'd1, "R6 pre");
    rd(2'd1, "R6 gated off");
    smode = 1; wdet = 1; rd(2'd1, "R6 pre");
    rd(2'd1, "R6 set");
    wr(2'd1, 8'hFC); rd(2'd1, "R1 bus clear");

    // R8 connection flag latency on rise and on fall
    wr(2'd0, 8'h00);
    vbus = 1;
    for (int k = 0; k < 5; k++) rd(2'd0, "R8 rise");
    wr(2'd0, 8'h00);
    vbus = 0;
    for (int k = 0; k < 5; k++) rd(2'd0, "R8 fall");

    // R9 masking
    wr(2'd2, 8'h80); rd(2'd2, "R9 spare bit");
    wr(2'd2, 8'h40); rd(2'd0, "R9 conn enabled");
    wr(2'd3, 8'hFF); rd(2'd3, "R9 bus enables");
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); rd(2'd0, "R9 quiet");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom;
      if (r[3:0] == 0) vbus = ~vbus;
      if (r[7:4] == 0) smode = ~smode;
      if (r[11:8] == 0) cfg = ~cfg;
      treq  = (r[13:12] == 0) ? 3'($urandom) : '0;
      tdone = (r[15:14] == 0) ? 3'($urandom) : '0;
      sdet  = (r[18:16] == 0);
      wdet  = (r[21:19] == 0);
      cs    = r[22] | r[23];
      we    = r[24] & r[25];
      addr  = r[27:26];
      wd    = 8'($urandom) | ((r[28]) ? 8'hF0 : 8'h00);
      run("R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule